// File: doc/BRIEF.md
# Background Scan Request Source

This block is the request side of a background conversion scan. Software programs a channel-select mask, and each load event copies that mask into a pending mask. A load event comes from a software write, from a chosen edge on a selected external trigger line, or from the block itself when autoscan is on. A load either replaces the pending mask or ORs the select mask into it. The block offers the lowest-numbered pending channel to a downstream arbiter. It drops that channel's pending bit when the arbiter reports the conversion as done. It also drops the bit on a cancel when repeat is disabled.

A gate input, chosen from several gate lines, can hold requests back: requests can be off, always on, on while the gate is high, or on while it is low. When the last pending channel completes, a sticky source-event flag is set and, if enabled, a one-cycle interrupt pulse is raised. With autoscan on, that same completion reloads the pending mask, so the scan runs continuously.

Register map: address 0 holds trigger/gate configuration and input status, address 1 the mode word, address 2 the select mask, address 3 the pending mask. Writes take effect at the clock edge. Reads are combinational.

Top module: `bgscan_src`

## Requirements
- R1: After reset the pending mask reads 0, no request is presented, and the source-event flag and interrupt are low.
- R2: A load event with the combine bit (mode bit 5) at 0 replaces the pending mask with the select mask (address 2).
- R3: A load event with the combine bit at 1 ORs the select mask into the pending mask.
- R4: The request carries the lowest-index pending channel. A done handshake on channel c clears pending bit c at the next edge.
- R5: Gate mode (mode bits 1:0) gives: 0 no requests, 1 request whenever a bit is pending, 2 only while the selected gate level is high, 3 only while it is low. The gate input passes two synchronizer flops.
- R6: Trigger mode (address 0 bits 5:4) gives: 0 none, 1 falling edge, 2 rising edge, 3 any edge, on the trigger line chosen by bits 2:0 after two synchronizer flops. An edge causes a load only while trigger enable (mode bit 2) is 1.
- R7: A done that clears the last pending bit sets the source-event flag (output, and mode read bit 12). The flag stays set until a write of mode bit 10. It also raises the interrupt for one cycle when interrupt enable (mode bit 3) is 1.
- R8: With autoscan (mode bit 4) at 1, the completion that sets the source event also performs a load event in the same cycle.
- R9: Writing mode bit 9 as 1 performs a load event. Writing mode bit 8 as 1 clears the pending mask.
- R10: Trigger select and trigger mode change only in a write to address 0 with bit 7 set. Gate select (bits 10:8) changes only with bit 11 set.
- R11: A cancel on a pending channel leaves it pending when repeat-disable (mode bit 6) is 0, and clears it when that bit is 1.
- R12: Address 0 reads the synchronized selected trigger level in bit 16 and the gate level in bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data (combinational) |
| trig_in | input | NTRIG | External trigger lines |
| gate_in | input | NGATE | Gate lines |
| conv_done | input | 1 | Conversion finished for conv_ch |
| conv_cancel | input | 1 | Conversion cancelled for conv_ch |
| conv_ch | input | CH_W | Channel of the done/cancel handshake |
| req_valid | output | 1 | A channel is requested |
| req_ch | output | CH_W | Requested channel number |
| src_event | output | 1 | Sticky source-event flag |
| src_irq | output | 1 | One-cycle source interrupt |

## Verification
Six load vectors mix empty, partial, full and disjoint pending and select masks under both load modes. They separate replace from OR, and they show that a zero select mask empties the mask in replace mode but leaves it alone in combine mode. The directed tests then drive each trigger edge type against its opposite edge, which separates rising, falling and any-edge detection and shows the enable gating. Each gate mode is run at both gate levels. Completion tests cover the last channel with the interrupt on and off, the autoscan reload, and cancel with repeat on and off.

// File: rtl/bgscan_pkg.sv
package bgscan_pkg;

   typedef enum logic [1:0] {
      A_TRIG = 2'd0,
      A_MODE = 2'd1,
      A_SEL  = 2'd2,
      A_PEND = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      GATE_OFF    = 2'd0,
      GATE_ALWAYS = 2'd1,
      GATE_HIGH   = 2'd2,
      GATE_LOW    = 2'd3
   } gate_mode_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_RISE = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_mode_e;

   typedef struct packed {
      logic [2:0] trig_sel;
      edge_mode_e trig_mode;
      logic [2:0] gate_sel;
      gate_mode_e gate_mode;
      logic       trig_en;
      logic       int_en;
      logic       autoscan;
      logic       combine;
      logic       rpt_dis;
   } cfg_t;

   // field positions, address 0
   localparam int B_TWC   = 7;
   localparam int B_GWC   = 11;
   localparam int B_TLVL  = 16;
   localparam int B_GLVL  = 17;
   // field positions, address 1
   localparam int B_TEN   = 2;
   localparam int B_IEN   = 3;
   localparam int B_ASCAN = 4;
   localparam int B_COMB  = 5;
   localparam int B_RPTD  = 6;
   localparam int B_CLRP  = 8;
   localparam int B_LOAD  = 9;
   localparam int B_CLRF  = 10;
   localparam int B_FLAG  = 12;

endpackage

// File: rtl/bgscan_sync.sv
module bgscan_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("bgscan_sync: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0] st;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= 1'b0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= 1'b0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[DEPTH-1];
endmodule

// File: rtl/bgscan_trig.sv
module bgscan_trig
   import bgscan_pkg::*;
#(
   parameter int NTRIG      = 8,
   parameter int NGATE      = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [NGATE-1:0] gate_in,
   input  cfg_t             cfg,
   output logic             trig_lvl,
   output logic             gate_lvl,
   output logic             trig_edge
);
   localparam int SEL_N = 8;

   logic [SEL_N-1:0] trig_pad, gate_pad;
   logic             trig_raw, gate_raw, trig_prev;
   logic             rise, fall;

   always_comb begin
      trig_pad = '0;
      gate_pad = '0;
      trig_pad[NTRIG-1:0] = trig_in;
      gate_pad[NGATE-1:0] = gate_in;
   end

   assign trig_raw = trig_pad[cfg.trig_sel];
   assign gate_raw = gate_pad[cfg.gate_sel];

   bgscan_sync #(.DEPTH(SYNC_DEPTH)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .d(trig_raw), .q(trig_lvl));

   bgscan_sync #(.DEPTH(SYNC_DEPTH)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .d(gate_raw), .q(gate_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_prev <= 1'b0;
      else        trig_prev <= trig_lvl;
   end

   assign rise = trig_lvl & ~trig_prev;
   assign fall = ~trig_lvl & trig_prev;

   always_comb begin
      case (cfg.trig_mode)
         EDGE_FALL: trig_edge = fall;
         EDGE_RISE: trig_edge = rise;
         EDGE_ANY:  trig_edge = rise | fall;
         default:   trig_edge = 1'b0;
      endcase
   end
endmodule

// File: rtl/bgscan_regs.sv
module bgscan_regs
   import bgscan_pkg::*;
#(
   parameter int NCH = 8,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic [1:0]     rd_addr,
   output logic [DW-1:0]  rd_data,
   input  logic [NCH-1:0] pend,
   input  logic           flag,
   input  logic           trig_lvl,
   input  logic           gate_lvl,
   output cfg_t           cfg,
   output logic [NCH-1:0] sel_mask,
   output logic           pend_wr,
   output logic [NCH-1:0] pend_data,
   output logic           clr_pend,
   output logic           sw_load,
   output logic           flag_clr
);
   logic hit_trig, hit_mode, hit_sel;

   assign hit_trig = wr_en && (wr_addr == A_TRIG);
   assign hit_mode = wr_en && (wr_addr == A_MODE);
   assign hit_sel  = wr_en && (wr_addr == A_SEL);
   assign pend_wr  = wr_en && (wr_addr == A_PEND);

   assign pend_data = wr_data[NCH-1:0];
   assign clr_pend  = hit_mode && wr_data[B_CLRP];
   assign sw_load   = hit_mode && wr_data[B_LOAD];
   assign flag_clr  = hit_mode && wr_data[B_CLRF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         sel_mask <= '0;
      end else begin
         if (hit_trig && wr_data[B_TWC]) begin
            cfg.trig_sel  <= wr_data[2:0];
            cfg.trig_mode <= edge_mode_e'(wr_data[5:4]);
         end
         if (hit_trig && wr_data[B_GWC]) begin
            cfg.gate_sel <= wr_data[10:8];
         end
         if (hit_mode) begin
            cfg.gate_mode <= gate_mode_e'(wr_data[1:0]);
            cfg.trig_en   <= wr_data[B_TEN];
            cfg.int_en    <= wr_data[B_IEN];
            cfg.autoscan  <= wr_data[B_ASCAN];
            cfg.combine   <= wr_data[B_COMB];
            cfg.rpt_dis   <= wr_data[B_RPTD];
         end
         if (hit_sel) sel_mask <= wr_data[NCH-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_addr_e'(rd_addr))
         A_TRIG: begin
            rd_data[2:0]   = cfg.trig_sel;
            rd_data[5:4]   = cfg.trig_mode;
            rd_data[10:8]  = cfg.gate_sel;
            rd_data[B_TLVL] = trig_lvl;
            rd_data[B_GLVL] = gate_lvl;
         end
         A_MODE: begin
            rd_data[1:0]     = cfg.gate_mode;
            rd_data[B_TEN]   = cfg.trig_en;
            rd_data[B_IEN]   = cfg.int_en;
            rd_data[B_ASCAN] = cfg.autoscan;
            rd_data[B_COMB]  = cfg.combine;
            rd_data[B_RPTD]  = cfg.rpt_dis;
            rd_data[B_FLAG]  = flag;
         end
         A_SEL:   rd_data[NCH-1:0] = sel_mask;
         default: rd_data[NCH-1:0] = pend;
      endcase
   end
endmodule

// File: rtl/bgscan_pend.sv
module bgscan_pend #(
   parameter int NCH  = 8,
   parameter int CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  sel_mask,
   input  logic            pend_wr,
   input  logic [NCH-1:0]  pend_data,
   input  logic            clr_pend,
   input  logic            load_req,
   input  logic            autoscan,
   input  logic            combine,
   input  logic            rpt_dis,
   input  logic            conv_done,
   input  logic            conv_cancel,
   input  logic [CH_W-1:0] conv_ch,
   input  logic            gate_ok,
   output logic [NCH-1:0]  pend,
   output logic            req_valid,
   output logic [CH_W-1:0] req_ch,
   output logic            src_evt,
   output logic            load_evt
);
   logic [NCH-1:0] ch_hot, nxt;
   logic           done_hit, found;

   assign ch_hot   = NCH'(1) << conv_ch;
   assign done_hit = conv_done && |(pend & ch_hot);
   assign src_evt  = done_hit && ((pend & ~ch_hot) == '0);
   assign load_evt = load_req || (src_evt && autoscan);

   always_comb begin
      nxt = pend_wr ? pend_data : pend;
      if (conv_done || (conv_cancel && rpt_dis)) nxt = nxt & ~ch_hot;
      if (clr_pend) nxt = '0;
      if (load_evt) nxt = combine ? (nxt | sel_mask) : sel_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= nxt;
   end

   // lowest index wins
   always_comb begin
      found  = 1'b0;
      req_ch = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend[i]) begin
            found  = 1'b1;
            req_ch = CH_W'(i);
         end
      end
   end

   assign req_valid = found && gate_ok;
endmodule

// File: rtl/bgscan_src.sv
module bgscan_src
   import bgscan_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int NTRIG      = 8,
   parameter int NGATE      = 8,
   parameter int DW         = 32,
   parameter int SYNC_DEPTH = 2,
   localparam int CH_W      = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [1:0]       rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [NGATE-1:0] gate_in,
   input  logic             conv_done,
   input  logic             conv_cancel,
   input  logic [CH_W-1:0]  conv_ch,
   output logic             req_valid,
   output logic [CH_W-1:0]  req_ch,
   output logic             src_event,
   output logic             src_irq
);
   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("bgscan_src: NCH must be 2..16");
   end
   if (NTRIG < 1 || NTRIG > 8 || NGATE < 1 || NGATE > 8) begin : g_bad_lines
      $error("bgscan_src: NTRIG and NGATE must be 1..8");
   end
   if (DW < 18) begin : g_bad_dw
      $error("bgscan_src: DW must be at least 18");
   end

   cfg_t           cfg;
   logic [NCH-1:0] sel_mask, pend_data, pend;
   logic           pend_wr, clr_pend, sw_load, flag_clr;
   logic           trig_lvl, gate_lvl, trig_edge;
   logic           gate_ok, src_evt, load_evt, load_req;

   bgscan_regs #(.NCH(NCH), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pend(pend), .flag(src_event),
      .trig_lvl(trig_lvl), .gate_lvl(gate_lvl),
      .cfg(cfg), .sel_mask(sel_mask),
      .pend_wr(pend_wr), .pend_data(pend_data),
      .clr_pend(clr_pend), .sw_load(sw_load), .flag_clr(flag_clr));

   bgscan_trig #(.NTRIG(NTRIG), .NGATE(NGATE), .SYNC_DEPTH(SYNC_DEPTH)) u_trig (
      .clk(clk), .rst_n(rst_n),
      .trig_in(trig_in), .gate_in(gate_in), .cfg(cfg),
      .trig_lvl(trig_lvl), .gate_lvl(gate_lvl), .trig_edge(trig_edge));

   always_comb begin
      case (cfg.gate_mode)
         GATE_ALWAYS: gate_ok = 1'b1;
         GATE_HIGH:   gate_ok = gate_lvl;
         GATE_LOW:    gate_ok = ~gate_lvl;
         default:     gate_ok = 1'b0;
      endcase
   end

   assign load_req = sw_load || (trig_edge && cfg.trig_en);

   bgscan_pend #(.NCH(NCH), .CH_W(CH_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .sel_mask(sel_mask), .pend_wr(pend_wr), .pend_data(pend_data),
      .clr_pend(clr_pend), .load_req(load_req),
      .autoscan(cfg.autoscan), .combine(cfg.combine), .rpt_dis(cfg.rpt_dis),
      .conv_done(conv_done), .conv_cancel(conv_cancel), .conv_ch(conv_ch),
      .gate_ok(gate_ok),
      .pend(pend), .req_valid(req_valid), .req_ch(req_ch),
      .src_evt(src_evt), .load_evt(load_evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_event <= 1'b0;
         src_irq   <= 1'b0;
      end else begin
         src_irq <= src_evt && cfg.int_en;
         if (src_evt)       src_event <= 1'b1;
         else if (flag_clr) src_event <= 1'b0;
      end
   end
endmodule

// File: rtl/bgscan_src_chk.sv
module bgscan_src_chk #(
   parameter int NCH  = 8,
   parameter int CH_W = $clog2(NCH)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NCH-1:0]  pend,
   input logic            req_valid,
   input logic [CH_W-1:0] req_ch,
   input logic [1:0]      gate_mode,
   input logic            conv_done,
   input logic            conv_cancel,
   input logic [CH_W-1:0] conv_ch,
   input logic            load_evt,
   input logic            pend_wr,
   input logic            clr_pend,
   input logic            rpt_dis,
   input logic            int_en,
   input logic            flag_clr,
   input logic            src_event,
   input logic            src_irq
);
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend == '0) && !req_valid && !src_event && !src_irq);

   a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> pend[req_ch] &&
                    ((pend & ((NCH'(1) << req_ch) - NCH'(1))) == '0));

   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && !load_evt && !pend_wr |=> !pend[$past(conv_ch)]);

   a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_mode == 2'd0) |-> !req_valid);

   a_r7_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      src_irq |-> src_event);

   a_r7_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      src_irq |-> $past(int_en));

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      src_event && !flag_clr |=> src_event);

   a_r11_cancel_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      conv_cancel && !conv_done && !rpt_dis && !clr_pend && !load_evt &&
      !pend_wr && pend[conv_ch] |=> pend[$past(conv_ch)]);
endmodule

bind bgscan_src bgscan_src_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pend(pend), .req_valid(req_valid),
   .req_ch(req_ch), .gate_mode(cfg.gate_mode), .conv_done(conv_done),
   .conv_cancel(conv_cancel), .conv_ch(conv_ch), .load_evt(load_evt),
   .pend_wr(pend_wr), .clr_pend(clr_pend), .rpt_dis(cfg.rpt_dis),
   .int_en(cfg.int_en), .flag_clr(flag_clr), .src_event(src_event),
   .src_irq(src_irq));

// File: tb/bgscan_src_tb.sv
module bgscan_src_tb;
   localparam int NCH = 8;
   localparam int CHW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  trig_in = '0;
   logic [7:0]  gate_in = '0;
   logic        conv_done = 1'b0;
   logic        conv_cancel = 1'b0;
   logic [CHW-1:0] conv_ch = '0;
   logic        req_valid;
   logic [CHW-1:0] req_ch;
   logic        src_event, src_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bgscan_src u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trig_in(trig_in), .gate_in(gate_in), .conv_done(conv_done),
      .conv_cancel(conv_cancel), .conv_ch(conv_ch), .req_valid(req_valid),
      .req_ch(req_ch), .src_event(src_event), .src_irq(src_irq));

   // [24] combine, [23:16] initial pending, [15:8] select, [7:0] expected
   localparam logic [31:0] VEC [6] = '{
      {7'd0, 1'b0, 8'h00, 8'hA5, 8'hA5},
      {7'd0, 1'b0, 8'h3C, 8'hA5, 8'hA5},
      {7'd0, 1'b1, 8'h3C, 8'hA5, 8'hBD},
      {7'd0, 1'b0, 8'hFF, 8'h00, 8'h00},
      {7'd0, 1'b1, 8'h81, 8'h00, 8'h81},
      {7'd0, 1'b1, 8'h0F, 8'hF0, 8'hFF}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse_done(input int ch);
      @(negedge clk);
      conv_done = 1'b1; conv_ch = CHW'(ch);
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic pulse_cancel(input int ch);
      @(negedge clk);
      conv_cancel = 1'b1; conv_ch = CHW'(ch);
      @(negedge clk);
      conv_cancel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      summary();
   end

   initial begin
      logic [31:0] r;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(2'd3, r); chk("R1 pending after reset", r, 32'h0);
      chk("R1 request after reset", {31'd0, req_valid}, 32'd0);
      chk("R1 flag/irq after reset", {30'd0, src_event, src_irq}, 32'd0);

      // R2/R3/R9 load vectors
      for (int v = 0; v < 6; v++) begin
         logic [31:0] md;
         md = VEC[v][24] ? 32'h20 : 32'h0;
         wr(2'd3, {24'd0, VEC[v][23:16]});
         wr(2'd2, {24'd0, VEC[v][15:8]});
         wr(2'd1, md);
         wr(2'd1, md | 32'h200);
         rd(2'd3, r);
         chk(VEC[v][24] ? "R3 combine load (R9)" : "R2 overwrite load (R9)",
             r, {24'd0, VEC[v][7:0]});
      end

      // R4 priority and done, R5 gate modes
      wr(2'd2, 32'h28);
      wr(2'd1, 32'h001);
      wr(2'd1, 32'h201);
      chk("R4 request valid", {31'd0, req_valid}, 32'd1);
      chk("R4 lowest channel 3", {29'd0, req_ch}, 32'd3);
      pulse_done(3);
      chk("R4 next channel 5", {29'd0, req_ch}, 32'd5);
      chk("R7 no event while bits pending", {31'd0, src_event}, 32'd0);
      wr(2'd1, 32'h002);
      idle(3);
      chk("R5 mode2 gate low blocks", {31'd0, req_valid}, 32'd0);
      gate_in[0] = 1'b1;
      idle(3);
      chk("R5 mode2 gate high passes", {31'd0, req_valid}, 32'd1);
      wr(2'd1, 32'h003);
      chk("R5 mode3 gate high blocks", {31'd0, req_valid}, 32'd0);
      gate_in[0] = 1'b0;
      idle(3);
      chk("R5 mode3 gate low passes", {31'd0, req_valid}, 32'd1);
      wr(2'd1, 32'h000);
      chk("R5 mode0 blocks", {31'd0, req_valid}, 32'd0);

      // R7 last done with interrupt enabled
      wr(2'd1, 32'h009);
      pulse_done(5);
      chk("R7 irq pulse", {31'd0, src_irq}, 32'd1);
      chk("R7 flag set", {31'd0, src_event}, 32'd1);
      idle(1);
      chk("R7 irq one cycle", {31'd0, src_irq}, 32'd0);
      rd(2'd1, r); chk("R7 flag sticky read", {31'd0, r[12]}, 32'd1);
      wr(2'd1, 32'h409);
      chk("R7 flag cleared", {31'd0, src_event}, 32'd0);
      // interrupt disabled
      wr(2'd2, 32'h01);
      wr(2'd1, 32'h001);
      wr(2'd1, 32'h201);
      pulse_done(0);
      chk("R7 flag without irq", {30'd0, src_event, src_irq}, 32'd2);
      wr(2'd1, 32'h401);

      // R8 autoscan
      wr(2'd2, 32'h06);
      wr(2'd1, 32'h011);
      wr(2'd1, 32'h211);
      pulse_done(1);
      rd(2'd3, r); chk("R8 partial done", r, 32'h04);
      pulse_done(2);
      rd(2'd3, r); chk("R8 autoscan reload", r, 32'h06);
      chk("R8 event on reload", {31'd0, src_event}, 32'd1);

      // R9 clear pending
      wr(2'd1, 32'h511);
      rd(2'd3, r); chk("R9 clear pending", r, 32'h0);

      // R11 cancel
      wr(2'd1, 32'h001);
      wr(2'd1, 32'h201);
      pulse_cancel(1);
      rd(2'd3, r); chk("R11 cancel repeats", r, 32'h06);
      wr(2'd1, 32'h041);
      pulse_cancel(1);
      rd(2'd3, r); chk("R11 cancel discards", r, 32'h04);

      // R6 trigger edges, R10 guard
      wr(2'd1, 32'h100);
      wr(2'd2, 32'h01);
      wr(2'd0, 32'hA3);             // line 3, rising, write enabled
      wr(2'd1, 32'h004);            // trigger enabled, replace mode
      trig_in[3] = 1'b1; idle(4);
      rd(2'd3, r); chk("R6 rising edge loads", r, 32'h01);
      rd(2'd0, r); chk("R12 trigger level high", {31'd0, r[16]}, 32'd1);
      wr(2'd1, 32'h104);
      trig_in[3] = 1'b0; idle(4);
      rd(2'd3, r); chk("R6 falling ignored in rise mode", r, 32'h0);
      wr(2'd0, 32'h93);             // falling
      trig_in[3] = 1'b1; idle(4);
      rd(2'd3, r); chk("R6 rising ignored in fall mode", r, 32'h0);
      trig_in[3] = 1'b0; idle(4);
      rd(2'd3, r); chk("R6 falling edge loads", r, 32'h01);
      wr(2'd1, 32'h104);
      wr(2'd0, 32'h31);             // any edge, line 1, no write control
      rd(2'd0, r); chk("R10 guarded trigger fields unchanged", {24'd0, r[7:0]}, 32'h13);
      trig_in[3] = 1'b1; idle(4);
      rd(2'd3, r); chk("R10 mode kept as falling", r, 32'h0);
      wr(2'd0, 32'hB3);             // any edge
      trig_in[3] = 1'b0; idle(4);
      rd(2'd3, r); chk("R6 any edge loads", r, 32'h01);
      wr(2'd1, 32'h100);            // trigger disabled, clear
      trig_in[3] = 1'b1; idle(4);
      rd(2'd3, r); chk("R6 edge ignored when disabled", r, 32'h0);

      // R10 gate select guard, R12 gate level
      gate_in = 8'h02;
      wr(2'd0, 32'h100);
      idle(3);
      rd(2'd0, r); chk("R10 gate select guarded", {30'd0, r[17], r[8]}, 32'd0);
      wr(2'd0, 32'h900);
      idle(3);
      rd(2'd0, r); chk("R12 gate level after select", {31'd0, r[17]}, 32'd1);

      summary();
   end
endmodule